// File: doc/BRIEF.md
# Input Change Capture Register

This block watches a byte of digital inputs and records when any of them changes level. Each input owns two storage bits. A "captured" bit takes the changed level and holds it. A "previous" bit keeps the level from before the change. A level output, `chg_o`, tells the host that something needs attention. A one-cycle pulse, `rp_o`, marks each change that is detected on an unmasked input. External event sources also raise flags in a status byte, and every such flag holds `chg_o` high as well.

The host reads through a select and a one-cycle read strobe. Reading the captured byte moves it into the previous byte and re-arms capture. Reading the previous byte has no side effect. Reading the status byte clears it.

The upper half of the inputs can be masked. A masked input raises no indication of any kind. While masked, both of its storage bits follow the live input level.

Inputs pass through a two-flop synchronizer before change detection.

Top module: `din_change_tracker`

## Requirements
- R1: After reset, the previous byte, the captured byte and the status byte read as 0x00, and `chg_o` and `rp_o` are low.
- R2: A level change on an unmasked input, held steady from before a rising edge, appears in the captured byte and on `chg_o` after the third rising edge.
- R3: Once a captured bit has taken a change, it holds that value until the captured byte is read, whatever the input does in the meantime.
- R4: A read with `sel_i` = 0 returns the previous byte and alters no stored bit.
- R5: A read with `sel_i` = 1 returns the captured byte, copies every captured bit into its previous bit, and re-arms capture for every bit. A bit whose input now differs from its captured value is then detected again.
- R6: When `mask_i[k]` is 1, input 4+k drives neither `chg_o` nor `rp_o`, and its captured and previous bits both follow the synchronized input on every cycle.
- R7: A high on `evt_i[j]` (j from 0 to 5) sets status bit j and drives `chg_o` high. Status bit 6 is set by any detected input change. Status bit 7 always reads 0.
- R8: A read with `sel_i` = 2 returns the status byte, clears it, and drops `chg_o` if no input change is still pending.
- R9: After an input change, `chg_o` stays high until the host has read the status, previous and captured bytes, in any order. A new change restarts this set of three reads.
- R10: An event that arrives in the same cycle as a status read leaves its flag set after the read.
- R11: `rp_o` goes high for one cycle together with the captured update of each unmasked change.
- R12: `rdata_o` is combinational from the stored state: `sel_i` 0 selects the previous byte, 1 the captured byte, 2 the status byte, and 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 8 | Monitored inputs |
| mask_i | input | 4 | Mask bits for inputs 4..7 |
| evt_i | input | 6 | External event pulses |
| sel_i | input | 2 | Read select |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Read data for the selected byte |
| chg_o | output | 1 | Change indication |
| rp_o | output | 1 | Pulse on each unmasked detected change |

## Verification
Two pairs of functions can fall in the same cycle: an incoming event flag with the status read that clears the flags, and a re-detection with the captured-byte read that re-arms capture. The first pair is provoked by raising `evt_i` in the very cycle that the status strobe is high; the bench expects that flag to remain, and `chg_o` to stay high until a second status read. The second pair is provoked by moving a captured input back before the captured byte is read; the bench expects the previous byte to take the held value and the captured byte to show the new level a few cycles later, with `chg_o` held through a fresh set of three reads.

// File: rtl/din_chg_pkg.sv
package din_chg_pkg;
  typedef enum logic [1:0] {
    SEL_OLD  = 2'd0,
    SEL_NEW  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/din_sync.sv
module din_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/chg_slice.sv
module chg_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic masked_i,
  input  logic rd_new_i,
  output logic new_o,
  output logic old_o,
  output logic det_o
);
  logic new_q, old_q, armed_q;

  assign det_o = !masked_i && armed_q && (sync_i != new_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_q   <= 1'b0;
      old_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (masked_i) begin
      new_q   <= sync_i;
      old_q   <= sync_i;
      armed_q <= 1'b1;
    end else begin
      if (det_o)    new_q <= sync_i;
      if (rd_new_i) old_q <= new_q;
      // detection wins over re-arm in the same cycle
      if (det_o)         armed_q <= 1'b0;
      else if (rd_new_i) armed_q <= 1'b1;
    end
  end

  assign new_o = new_q;
  assign old_o = old_q;

  AST_HOLD_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !rd_new_i && !masked_i) |=> $stable(new_q)); // R3
  AST_OLD_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_new_i && !masked_i) |=> $stable(old_q)); // R4
  AST_SHIFT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_new_i && !masked_i) |=> (old_q == $past(new_q))); // R5
  AST_MASK_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_i |=> (new_q == $past(sync_i)) && (old_q == $past(sync_i))); // R6
endmodule

// File: rtl/chg_status.sv
module chg_status #(
  parameter int unsigned DW    = 8,
  parameter int unsigned EVT_N = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             inp_det_i,
  input  logic             rd_stat_i,
  input  logic             rd_old_i,
  input  logic             rd_new_i,
  output logic [DW-1:0]    stat_o,
  output logic             chg_o
);
  localparam int unsigned PAD_W = DW - EVT_N - 1;

  logic [EVT_N-1:0] flags_q;
  logic             inp_flag_q;
  logic             pend_q;
  logic [2:0]       seen_q, seen_d;

  assign seen_d = seen_q | {rd_new_i, rd_old_i, rd_stat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q    <= '0;
      inp_flag_q <= 1'b0;
      pend_q     <= 1'b0;
      seen_q     <= '0;
    end else begin
      flags_q <= rd_stat_i ? evt_i : (flags_q | evt_i);
      if (inp_det_i)      inp_flag_q <= 1'b1;
      else if (rd_stat_i) inp_flag_q <= 1'b0;
      if (inp_det_i) begin
        pend_q <= 1'b1;
        seen_q <= '0;
      end else if (pend_q && (&seen_d)) begin
        pend_q <= 1'b0;
        seen_q <= '0;
      end else begin
        seen_q <= seen_d;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign stat_o = {{PAD_W{1'b0}}, inp_flag_q, flags_q};
    end else begin : g_nopad
      assign stat_o = {inp_flag_q, flags_q};
    end
  endgenerate

  assign chg_o = (|flags_q) || pend_q;

  AST_EVT_RAISES_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> chg_o); // R7
  AST_STAT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !(|evt_i)) |=> (flags_q == '0)); // R8
  AST_EVT_ON_READ_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && (|evt_i)) |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R10
  AST_PEND_NEEDS_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(&(seen_q | {rd_new_i, rd_old_i, rd_stat_i}))); // R9
endmodule

// File: rtl/din_change_tracker.sv
module din_change_tracker
  import din_chg_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned MASK_LO = 4,
  parameter int unsigned EVT_N   = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DW-1:0]         din_i,
  input  logic [DW-MASK_LO-1:0] mask_i,
  input  logic [EVT_N-1:0]      evt_i,
  input  logic [1:0]            sel_i,
  input  logic                  rd_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  chg_o,
  output logic                  rp_o
);
  rd_sel_e       sel;
  logic [DW-1:0] sync, new_v, old_v, det_v, masked, stat;
  logic          rd_old, rd_new, rd_stat, rp_q;

  assign sel     = rd_sel_e'(sel_i);
  assign rd_old  = rd_i && (sel == SEL_OLD);
  assign rd_new  = rd_i && (sel == SEL_NEW);
  assign rd_stat = rd_i && (sel == SEL_STAT);

  din_sync #(.W(DW)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (sync)
  );

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i >= MASK_LO) begin : g_mskb
      assign masked[i] = mask_i[i-MASK_LO];
    end else begin : g_fixb
      assign masked[i] = 1'b0;
    end
    chg_slice i_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[i]),
      .masked_i(masked[i]),
      .rd_new_i(rd_new),
      .new_o   (new_v[i]),
      .old_o   (old_v[i]),
      .det_o   (det_v[i])
    );
  end

  chg_status #(.DW(DW), .EVT_N(EVT_N)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .inp_det_i(|det_v),
    .rd_stat_i(rd_stat),
    .rd_old_i (rd_old),
    .rd_new_i (rd_new),
    .stat_o   (stat),
    .chg_o    (chg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rp_q <= 1'b0;
    else         rp_q <= |det_v;
  end
  assign rp_o = rp_q;

  always_comb begin
    unique case (sel)
      SEL_OLD:  rdata_o = old_v;
      SEL_NEW:  rdata_o = new_v;
      SEL_STAT: rdata_o = stat;
      default:  rdata_o = '0;
    endcase
  end

  AST_RP_WITH_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_o |-> chg_o); // R11
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((det_v & masked) == '0)); // R6
endmodule

// File: tb/test_din_change_tracker.sv
`timescale 1ns/1ps
module test_din_change_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = '0;
  logic [3:0] mask = '0;
  logic [5:0] evt = '0;
  logic [1:0] sel = '0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       chg, rp;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  din_change_tracker i_din_change_tracker (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .mask_i(mask), .evt_i(evt),
    .sel_i(sel), .rd_i(rd), .rdata_o(rdata), .chg_o(chg), .rp_o(rp)
  );

  typedef struct packed {
    logic [7:0] din;
    logic [3:0] mask;
    logic [1:0] sel;
    logic [7:0] exp_rd;
    logic       exp_chg;
  } vec_t;

  // each step: apply, settle 4 cycles, check, then strobe a read
  localparam vec_t VEC [0:13] = '{
    '{8'h01, 4'h0, 2'd1, 8'h01, 1'b1},
    '{8'h01, 4'h0, 2'd0, 8'h01, 1'b1},
    '{8'h01, 4'h0, 2'd2, 8'h40, 1'b1},
    '{8'h01, 4'h0, 2'd2, 8'h00, 1'b0},
    '{8'h03, 4'h0, 2'd0, 8'h01, 1'b1},
    '{8'h01, 4'h0, 2'd1, 8'h03, 1'b1},
    '{8'h01, 4'h0, 2'd0, 8'h03, 1'b1},
    '{8'h01, 4'h0, 2'd1, 8'h01, 1'b1},
    '{8'h01, 4'h0, 2'd2, 8'h40, 1'b1},
    '{8'h01, 4'h0, 2'd2, 8'h00, 1'b0},
    '{8'hF1, 4'hF, 2'd1, 8'hF1, 1'b0},
    '{8'h31, 4'hF, 2'd0, 8'h31, 1'b0},
    '{8'h31, 4'h0, 2'd1, 8'h31, 1'b0},
    '{8'h31, 4'h0, 2'd3, 8'h00, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] s);
    sel = s;
    rd = 1'b1;
    tick();
    rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, input string tag, input logic [7:0] exp);
    sel = s;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    peek(2'd0, "R1 old after reset", 8'h00);
    peek(2'd1, "R1 new after reset", 8'h00);
    peek(2'd2, "R1 status after reset", 8'h00);
    chk("R1 chg after reset", {7'd0, chg}, 8'h00);
    chk("R1 rp after reset", {7'd0, rp}, 8'h00);
    rst_n = 1'b1;
    tick();

    // table: R3 hold, R4 old read, R5 shift, R6 mask, R9 three reads, R12 select
    foreach (VEC[i]) begin
      din  = VEC[i].din;
      mask = VEC[i].mask;
      sel  = VEC[i].sel;
      repeat (4) tick();
      chk($sformatf("R3 R4 R5 R6 R9 R12 vec %0d rdata", i), rdata, VEC[i].exp_rd);
      chk($sformatf("R9 vec %0d chg", i), {7'd0, chg}, {7'd0, VEC[i].exp_chg});
      strobe(VEC[i].sel);
    end

    // R2 and R11 latency: input 0 drops
    sel = 2'd1;
    din = 8'h30;
    tick();
    tick();
    chk("R2 new before third edge", rdata, 8'h31);
    chk("R11 rp before third edge", {7'd0, rp}, 8'h00);
    tick();
    chk("R2 new after third edge", rdata, 8'h30);
    chk("R2 chg after third edge", {7'd0, chg}, 8'h01);
    chk("R11 rp pulse high", {7'd0, rp}, 8'h01);
    tick();
    chk("R11 rp one cycle", {7'd0, rp}, 8'h00);
    strobe(2'd1);
    strobe(2'd0);
    chk("R9 chg after two reads", {7'd0, chg}, 8'h01);
    strobe(2'd2);
    chk("R9 chg after three reads", {7'd0, chg}, 8'h00);

    // R6 masked input raises no pulse
    mask = 4'h1;
    din  = 8'h20;
    begin
      logic seen_ind;
      seen_ind = 1'b0;
      for (int k = 0; k < 6; k++) begin
        tick();
        seen_ind = seen_ind | rp | chg;
      end
      chk("R6 masked change silent", {7'd0, seen_ind}, 8'h00);
    end
    peek(2'd0, "R6 masked old tracks", 8'h20);
    mask = 4'h0;
    tick();

    // R7 event flag, R8 clear on status read
    evt = 6'h04;
    tick();
    evt = 6'h00;
    peek(2'd2, "R7 status flag", 8'h04);
    chk("R7 chg on event", {7'd0, chg}, 8'h01);
    peek(2'd3, "R12 select 3 reads zero", 8'h00);
    strobe(2'd2);
    peek(2'd2, "R8 status cleared", 8'h00);
    chk("R8 chg cleared", {7'd0, chg}, 8'h00);

    // R10 event coincides with status read
    evt = 6'h21;
    tick();
    evt = 6'h20;
    sel = 2'd2;
    rd  = 1'b1;
    tick();
    rd  = 1'b0;
    evt = 6'h00;
    peek(2'd2, "R10 flag kept across read", 8'h20);
    chk("R10 chg kept", {7'd0, chg}, 8'h01);
    strobe(2'd2);
    chk("R8 chg cleared after second read", {7'd0, chg}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule